// File: doc/BRIEF.md
# Contact Card Power-Up and Answer-to-Reset Supervisor

This controller sits on the reader side of a contact card slot. It applies power to a card once the slot reports the card is seated. It then starts the card clock with the reader's data line listening and the reset line low. After a fixed number of card clock cycles it raises reset, and it then watches the answer-to-reset bytes coming back from the character receiver.

The first reply byte has a deadline counted in card clock cycles. Each later byte must follow the previous one within a wall-time interval. That interval is given as a count of system clocks per second, so the block works with any system clock rate. The answer ends when a programmed byte count is reached or when the answer parser pulses a done strobe. The block then reports that the card is active.

Removing the card at any point, or missing a byte deadline, shuts the contacts down one step per system clock. Reset goes low first, then the clock stops, then the data line is released, and supply goes off last. A deactivated status is then shown. After a timeout the block does not retry while the card stays seated; taking the card out returns the block to idle.

Top module: `card_activation_seq`

## Requirements
- R1: While no card is seated, vcc_en, cclk_en, io_rx, card_rst, active, atr_timeout and deactivated are all 0. vpp_idle is 1 at all times.
- R2: In the clock after card_present is first seen high, vcc_en is 1 and everything else is off. In the following clock, cclk_en and io_rx (1 = reader I/O in receive mode) go high while card_rst stays 0.
- R3: card_rst goes high only after exactly RST_HOLD_CLKS card clock ticks (card_clk_en high) have been counted while cclk_en is 1 and card_rst is 0.
- R4: After card_rst rises, if FIRST_BYTE_CLKS card clock ticks pass without a byte_rx pulse, atr_timeout is set and deactivation starts. A byte on the last allowed tick is still accepted.
- R5: Once the first byte is in, a byte_rx pulse arriving ticks_per_sec system clocks after the previous one is still accepted. If ticks_per_sec clocks pass after a byte with no new byte, atr_timeout is set and deactivation starts.
- R6: active goes high when the received byte count equals a nonzero atr_len, or when atr_done pulses after the first byte. While active, supply, clock, I/O receive and reset high all stay on.
- R7: Deactivation shows one state per system clock, as (vcc_en,cclk_en,io_rx,card_rst): 1110, then 1010, then 1000, then 0000 with deactivated = 1. If power was only on the supply step when deactivation began, the sequence goes straight from 1000 to off.
- R8: card_present going low in any powered state starts deactivation. Once the card is absent in the deactivated state, the block returns to idle in the next clock, with atr_timeout and deactivated cleared.
- R9: atr_timeout stays 1, and the block stays deactivated with every contact off, for as long as the card remains seated after a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_present | input | 1 | Card seated and aligned in the slot |
| card_clk_en | input | 1 | One-cycle tick per card clock period |
| byte_rx | input | 1 | Character receiver got a reply byte |
| atr_done | input | 1 | Answer parser reports the reply complete |
| atr_len | input | LEN_W | Expected reply length in bytes, 0 = wait for atr_done |
| ticks_per_sec | input | SEC_W | System clocks per second for the gap watchdog |
| vcc_en | output | 1 | Card supply enable |
| cclk_en | output | 1 | Card clock drive enable |
| card_rst | output | 1 | Card reset line level |
| io_rx | output | 1 | Reader I/O in receive mode (0 = released) |
| vpp_idle | output | 1 | Programming supply held at idle level |
| active | output | 1 | Card answered and is ready |
| atr_timeout | output | 1 | A reply byte deadline was missed |
| deactivated | output | 1 | Contacts have been shut down |

## Verification
The in-line assertions check on every cycle that no contact is driven without supply, that reset never rises before the full low-hold count, that the clock stops only with reset already low and the data line is released only with the clock stopped, and that the active state always has every contact driven. The byte deadlines, the byte-count and done-strobe endings, the removal paths and the no-retry hold after a timeout can only be shown by the bench's scenarios. In those scenarios a behavioural model follows the card clock divider, the reply timing and the slot state, and is compared on every clock.

// File: rtl/card_activation_seq.sv
module card_activation_seq #(
  parameter int RST_HOLD_CLKS   = 40000,
  parameter int FIRST_BYTE_CLKS = 40000,
  parameter int SEC_W           = 32,
  parameter int LEN_W           = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_present,
  input  logic             card_clk_en,
  input  logic             byte_rx,
  input  logic             atr_done,
  input  logic [LEN_W-1:0] atr_len,
  input  logic [SEC_W-1:0] ticks_per_sec,
  output logic             vcc_en,
  output logic             cclk_en,
  output logic             card_rst,
  output logic             io_rx,
  output logic             vpp_idle,
  output logic             active,
  output logic             atr_timeout,
  output logic             deactivated
);

  localparam int CMAX = (RST_HOLD_CLKS > FIRST_BYTE_CLKS) ? RST_HOLD_CLKS : FIRST_BYTE_CLKS;
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(RST_HOLD_CLKS - 1);
  localparam logic [CW-1:0] FIRST_LAST = CW'(FIRST_BYTE_CLKS - 1);

  typedef enum logic [3:0] {
    S_OFF, S_VCC, S_HOLD, S_WAIT1, S_BYTES, S_ACTIVE,
    S_DRST, S_DCLK, S_DIO, S_DONE
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [SEC_W-1:0] sec;
  logic [LEN_W-1:0] nbytes;
  logic             tmo;
  logic             live;

  assign live = (st == S_VCC) || (st == S_HOLD) || (st == S_WAIT1) ||
                (st == S_BYTES) || (st == S_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      cnt    <= '0;
      sec    <= '0;
      nbytes <= '0;
      tmo    <= 1'b0;
    end else if (live && !card_present) begin
      st <= (st == S_VCC) ? S_DIO : S_DRST;
    end else begin
      case (st)
        S_OFF:   if (card_present) st <= S_VCC;
        S_VCC: begin
          cnt <= '0;
          st  <= S_HOLD;
        end
        S_HOLD:
          if (card_clk_en) begin
            if (cnt == HOLD_LAST) begin
              cnt <= '0;
              st  <= S_WAIT1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        S_WAIT1:
          if (byte_rx) begin
            nbytes <= LEN_W'(1);
            sec    <= '0;
            st     <= (atr_len == LEN_W'(1)) ? S_ACTIVE : S_BYTES;
          end else if (card_clk_en) begin
            if (cnt == FIRST_LAST) begin
              tmo <= 1'b1;
              st  <= S_DRST;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        S_BYTES:
          if (atr_done) begin
            st <= S_ACTIVE;
          end else if (byte_rx) begin
            nbytes <= nbytes + LEN_W'(1);
            sec    <= '0;
            if (nbytes + LEN_W'(1) == atr_len) st <= S_ACTIVE;
          end else if (sec == ticks_per_sec - SEC_W'(1)) begin
            tmo <= 1'b1;
            st  <= S_DRST;
          end else begin
            sec <= sec + SEC_W'(1);
          end
        S_DRST:  st <= S_DCLK;
        S_DCLK:  st <= S_DIO;
        S_DIO:   st <= S_DONE;
        S_DONE:
          if (!card_present) begin
            tmo <= 1'b0;
            st  <= S_OFF;
          end
        default: st <= st;
      endcase
    end
  end

  assign vcc_en      = (st != S_OFF) && (st != S_DONE);
  assign cclk_en     = (st != S_OFF) && (st != S_DONE) && (st != S_VCC) &&
                       (st != S_DCLK) && (st != S_DIO);
  assign io_rx       = cclk_en || (st == S_DCLK);
  assign card_rst    = (st == S_WAIT1) || (st == S_BYTES) || (st == S_ACTIVE);
  assign vpp_idle    = 1'b1;
  assign active      = (st == S_ACTIVE);
  assign atr_timeout = tmo;
  assign deactivated = (st == S_DONE);

  int lo_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_ticks <= 0;
    else if (!cclk_en) lo_ticks <= 0;
    else if (!card_rst && card_clk_en) lo_ticks <= lo_ticks + 1;
  end

  p_supply_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_en || card_rst || io_rx) |-> vcc_en);

  p_hold_before_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst) |-> (lo_ticks >= RST_HOLD_CLKS));

  p_clk_stop_after_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk_en) |-> (!card_rst && $past(!card_rst)));

  p_io_release_after_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_rx) |-> (!cclk_en && $past(!cclk_en)));

  p_vcc_off_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> ($past(!io_rx) && !cclk_en && !card_rst));

  p_active_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (vcc_en && cclk_en && io_rx && card_rst && !atr_timeout));

endmodule

// File: tb/test_card_activation_seq.sv
module test_card_activation_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD  = 50;
  localparam int FIRST = 60;
  localparam int TPS   = 100;

  logic clk = 0, rst_n = 0;
  logic card_present = 0, card_clk_en = 0, byte_rx = 0, atr_done = 0;
  logic [5:0]  atr_len = 0;
  logic [15:0] ticks_per_sec = 16'(TPS);
  logic vcc_en, cclk_en, card_rst, io_rx, vpp_idle, active, atr_timeout, deactivated;

  card_activation_seq #(.RST_HOLD_CLKS(HOLD), .FIRST_BYTE_CLKS(FIRST), .SEC_W(16), .LEN_W(6)) i_card_activation_seq (
    .clk(clk), .rst_n(rst_n), .card_present(card_present), .card_clk_en(card_clk_en),
    .byte_rx(byte_rx), .atr_done(atr_done), .atr_len(atr_len), .ticks_per_sec(ticks_per_sec),
    .vcc_en(vcc_en), .cclk_en(cclk_en), .card_rst(card_rst), .io_rx(io_rx), .vpp_idle(vpp_idle),
    .active(active), .atr_timeout(atr_timeout), .deactivated(deactivated));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  int div = 1, dcnt = 0, lo_ticks = 0;
  always @(negedge clk) begin
    if (dcnt >= div - 1) begin dcnt = 0; card_clk_en = 1; end
    else begin dcnt++; card_clk_en = 0; end
    if (!cclk_en) lo_ticks = 0;
    else if (!card_rst && card_clk_en) lo_ticks++;
  end

  int ph = 0, mc = 0, ms = 0, mb = 0;
  bit mt = 0;
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin ph = 0; mc = 0; ms = 0; mb = 0; mt = 0; end
    else if (ph >= 1 && ph <= 5 && !card_present) ph = (ph == 1) ? 8 : 6;
    else case (ph)
      0: if (card_present) ph = 1;
      1: begin mc = 0; ph = 2; end
      2: if (card_clk_en) begin mc++; if (mc == HOLD) begin mc = 0; ph = 3; end end
      3: if (byte_rx) begin mb = 1; ms = 0; ph = (atr_len == 1) ? 5 : 4; end
         else if (card_clk_en) begin mc++; if (mc == FIRST) begin mt = 1; ph = 6; end end
      4: if (atr_done) ph = 5;
         else if (byte_rx) begin mb++; ms = 0; if (mb == int'(atr_len)) ph = 5; end
         else begin ms++; if (ms == TPS) begin mt = 1; ph = 6; end end
      6: ph = 7;
      7: ph = 8;
      8: ph = 9;
      9: if (!card_present) begin ph = 0; mt = 0; end
      default: ;
    endcase
  end

  always @(negedge clk) if (!done) begin
    chk("R2 model vcc_en", vcc_en, (ph >= 1 && ph <= 8));
    chk("R2 model cclk_en", cclk_en, (ph >= 2 && ph <= 6));
    chk("R7 model io_rx", io_rx, (ph >= 2 && ph <= 7));
    chk("R3 model card_rst", card_rst, (ph >= 3 && ph <= 5));
    chk("R6 model active", active, ph == 5);
    chk("R4 model atr_timeout", atr_timeout, mt);
    chk("R7 model deactivated", deactivated, ph == 9);
    chk("R1 model vpp_idle", vpp_idle, 1);
    if (cycles > 100000) begin
      chk("watchdog expired", 1, 0);
      finish_up();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_byte();
    byte_rx = 1; @(negedge clk); byte_rx = 0;
  endtask

  task automatic wait_rst();
    for (int i = 0; i < 2000 && !card_rst; i++) @(negedge clk);
  endtask

  function automatic int pins();
    return {28'd0, vcc_en, cclk_en, io_rx, card_rst};
  endfunction

  initial begin
    cyc(3);
    chk("R1 reset pins", pins(), 0);
    rst_n = 1;
    cyc(3);
    chk("R1 idle pins", pins(), 0);
    chk("R1 idle flags", {active, atr_timeout, deactivated}, 0);

    div = 1; atr_len = 3;
    card_present = 1;
    cyc(1);
    chk("R2 supply first", pins(), 4'b1000);
    cyc(1);
    chk("R2 clock and io next", pins(), 4'b1110);
    wait_rst();
    chk("R3 hold ticks", lo_ticks, HOLD);
    cyc(10); pulse_byte(); cyc(20); pulse_byte(); cyc(5); pulse_byte(); cyc(1);
    chk("R6 active after count", active, 1);
    card_present = 0;
    cyc(1); chk("R7 step rst low", pins(), 4'b1110);
    cyc(1); chk("R7 step clk off", pins(), 4'b1010);
    cyc(1); chk("R7 step io off", pins(), 4'b1000);
    cyc(1); chk("R7 step vcc off", pins(), 0);
    chk("R7 deactivated", deactivated, 1);
    cyc(1); chk("R8 back to idle", deactivated, 0);

    div = 3; atr_len = 3;
    card_present = 1;
    wait_rst();
    chk("R3 hold ticks slow clock", lo_ticks, HOLD);
    for (int i = 0; i < 2000 && !atr_timeout; i++) @(negedge clk);
    chk("R4 first byte timeout", atr_timeout, 1);
    cyc(4);
    chk("R9 deactivated", deactivated, 1);
    cyc(50);
    chk("R9 no retry pins", pins(), 0);
    chk("R9 flag held", atr_timeout, 1);
    card_present = 0;
    cyc(2);
    chk("R8 flag cleared", atr_timeout, 0);

    div = 2; atr_len = 0;
    card_present = 1;
    wait_rst();
    cyc(7); pulse_byte(); cyc(TPS - 1); pulse_byte();
    chk("R5 boundary gap accepted", atr_timeout, 0);
    cyc(TPS + 5);
    chk("R5 gap timeout", atr_timeout, 1);
    card_present = 0;
    cyc(6);

    div = 1; atr_len = 0;
    card_present = 1;
    wait_rst();
    cyc(3); pulse_byte(); cyc(4); pulse_byte(); cyc(2);
    atr_done = 1; cyc(1); atr_done = 0; cyc(1);
    chk("R6 active on done", active, 1);
    card_present = 0;
    cyc(6);

    div = 3;
    card_present = 1;
    cyc(20);
    card_present = 0;
    cyc(6);
    chk("R8 removal in hold pins", pins(), 0);
    chk("R8 removal no timeout", atr_timeout, 0);
    card_present = 1;
    cyc(1);
    card_present = 0;
    cyc(6);
    chk("R8 removal in supply step", pins(), 0);

    finish_up();
  end
endmodule